// File: doc/BRIEF.md
# Five-Element Bridge Switch Network with Fault Injection

This block models a small switch network of five bidirectional elements arranged as a bridge. The network feeds an inverting drive stage. Each element closes when its control line is high. The network conducts from end to end when at least one chain of closed elements joins its two terminals. The middle element links the two branches and can be crossed in either direction, so the network has four distinct paths.

Each element also has two fault-injection lines. One forces the element permanently closed (stuck-short) and the other forces it permanently open (stuck-open). Any mix of faults can be applied at once, on one element or on several. This makes the block a device under test for fault-detection experiments: a tester applies control patterns and compares the observed outputs with those of a healthy module.

Complemented variables are not formed inside the block. If a function needs a literal in both polarities, each polarity is fed on its own control line. A parameter selects whether both outputs leave the block directly or through a register stage with a synchronous reset.

Top module: `bridge_switch_net`

## Requirements
- R1: `conduct` is high exactly when at least one of four element sets is fully closed: {e0,e3}, {e1,e4}, {e0,e2,e4} or {e1,e2,e3}. Element ei is controlled by `sw_ctrl[i]` and faulted by `stk_short[i]` and `stk_open[i]`.
- R2: `drive_n` is always the logical complement of `conduct`, except while the output register is held cleared by reset.
- R3: When `stk_short[i]` is 1, element ei counts as closed whatever the value of `sw_ctrl[i]`.
- R4: When `stk_open[i]` is 1, element ei counts as open whatever the value of `sw_ctrl[i]`.
- R5: When both `stk_short[i]` and `stk_open[i]` are 1, element ei behaves as open.
- R6: Faults on several elements at once are applied element by element, each as in R3 to R5, and are then combined through the path function of R1.
- R7: With both fault masks at zero, the outputs follow the fault-free bridge function for all 32 control patterns.
- R8: Element e2 serves both crossing paths. Control pattern 5'b10101 (e0, e2, e4) and control pattern 5'b01110 (e1, e2, e3) each make the network conduct.
- R9: With `REG_OUT`=1 (the default), both outputs are loaded on the rising edge of `clk`, one cycle after their inputs. A high `rst` at a rising edge sets both `conduct` and `drive_n` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high; clears the output register |
| sw_ctrl | input | 5 | Control line of each element; bit i drives element ei |
| stk_short | input | 5 | Per-element stuck-short fault injection |
| stk_open | input | 5 | Per-element stuck-open fault injection |
| conduct | output | 1 | Network conduction function |
| drive_n | output | 1 | Inverted module output |

## Verification
Two functions can act on the same element in the same cycle. A stuck-short and a stuck-open can target one element together, and a fault can contradict the element's own control line. The bench provokes both cases by sweeping every control pattern with each single-element mask, with both masks set on one element, and with random combinations of faults on several elements. Each cycle, a behavioural model in the bench applies the priority rule element by element and then evaluates the path function, and the outputs are compared against that model. A reset raised while the network conducts is also checked, to confirm that the clear wins over the registered data.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

   localparam int unsigned N_ELEM = 5;
   localparam int unsigned N_PATH = 4;

   typedef logic [N_ELEM-1:0] elem_vec_t;

   // Effective state of one element after fault resolution
   typedef enum logic [1:0] {
      SW_FOLLOW = 2'd0,
      SW_SHORT  = 2'd1,
      SW_OPEN   = 2'd2
   } sw_mode_e;

   // Element membership of each path (bit i = element ei)
   localparam elem_vec_t PATH_SET [N_PATH] = '{
      5'b01001,   // e0-e3 direct
      5'b10010,   // e1-e4 direct
      5'b10101,   // e0-e2-e4 crossing
      5'b01110    // e1-e2-e3 crossing
   };

   function automatic sw_mode_e resolve_mode(input logic shrt, input logic opn);
      if (opn)       return SW_OPEN;
      else if (shrt) return SW_SHORT;
      else           return SW_FOLLOW;
   endfunction

endpackage

// File: rtl/bsn_switch_cell.sv
module bsn_switch_cell
   import bsn_pkg::*;
(
   input  logic ctrl_i,
   input  logic short_i,
   input  logic open_i,
   output logic closed_o
);

   sw_mode_e mode;

   always_comb begin
      mode = resolve_mode(short_i, open_i);
      unique case (mode)
         SW_SHORT: closed_o = 1'b1;
         SW_OPEN:  closed_o = 1'b0;
         default:  closed_o = ctrl_i;
      endcase
   end

endmodule

// File: rtl/bsn_path_eval.sv
module bsn_path_eval
   import bsn_pkg::*;
#(
   parameter int unsigned N_SW  = N_ELEM,
   parameter int unsigned N_PTH = N_PATH
) (
   input  logic [N_SW-1:0] closed_i,
   output logic            conduct_o
);

   logic [N_PTH-1:0] path_ok;

   for (genvar p = 0; p < N_PTH; p++) begin : g_path
      localparam logic [N_SW-1:0] MEMBERS = PATH_SET[p];
      always_comb begin
         path_ok[p] = ((closed_i & MEMBERS) == MEMBERS);
      end
   end

   assign conduct_o = |path_ok;

endmodule

// File: rtl/bsn_out_stage.sv
module bsn_out_stage #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic cond_i,
   output logic conduct_o,
   output logic drive_n_o
);

   if (REG_OUT) begin : g_reg
      logic cond_q;
      logic drv_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            cond_q <= 1'b0;
            drv_q  <= 1'b0;
         end else begin
            cond_q <= cond_i;
            drv_q  <= ~cond_i;
         end
      end
      assign conduct_o = cond_q;
      assign drive_n_o = drv_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign conduct_o = cond_i;
      assign drive_n_o = ~cond_i;
   end

endmodule

// File: rtl/bridge_switch_net.sv
module bridge_switch_net
   import bsn_pkg::*;
#(
   parameter int unsigned N_SW    = 5,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_SW-1:0] sw_ctrl,
   input  logic [N_SW-1:0] stk_short,
   input  logic [N_SW-1:0] stk_open,
   output logic            conduct,
   output logic            drive_n
);

   localparam int unsigned N_PTH = N_PATH;

   if (N_SW != N_ELEM) begin : g_bad_width
      $error("bridge_switch_net: N_SW must equal the bridge element count");
   end

   logic [N_SW-1:0] elem_closed;
   logic            cond_raw;

   for (genvar i = 0; i < N_SW; i++) begin : g_cell
      bsn_switch_cell u_cell (
         .ctrl_i   (sw_ctrl[i]),
         .short_i  (stk_short[i]),
         .open_i   (stk_open[i]),
         .closed_o (elem_closed[i])
      );
   end

   bsn_path_eval #(
      .N_SW  (N_SW),
      .N_PTH (N_PTH)
   ) u_paths (
      .closed_i  (elem_closed),
      .conduct_o (cond_raw)
   );

   bsn_out_stage #(
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .cond_i    (cond_raw),
      .conduct_o (conduct),
      .drive_n_o (drive_n)
   );

endmodule

// File: rtl/bsn_checker.sv
module bsn_checker #(
   parameter int unsigned N_SW    = 5,
   parameter bit          REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic [N_SW-1:0] sw_ctrl,
   input logic [N_SW-1:0] stk_short,
   input logic [N_SW-1:0] stk_open,
   input logic            cond_raw,
   input logic            conduct,
   input logic            drive_n
);

   // R4: e0 and e1 open cut every path
   p_open_cut_r4: assert property (@(posedge clk) disable iff (rst)
      (stk_open[0] && stk_open[1]) |-> !cond_raw);

   // R3: shorted e0 and e3 (not open) always close a path
   p_short_path_r3: assert property (@(posedge clk) disable iff (rst)
      (stk_short[0] && stk_short[3] && !stk_open[0] && !stk_open[3]) |-> cond_raw);

   // R5: every element carries both faults, so open wins everywhere
   p_open_wins_r5: assert property (@(posedge clk) disable iff (rst)
      ((&stk_short) && (&stk_open)) |-> !cond_raw);

   // R8: crossing path through e2 conducts when healthy
   p_cross_r8: assert property (@(posedge clk) disable iff (rst)
      ((sw_ctrl == 5'b01110) && (stk_open == '0)) |-> cond_raw);

   // R2: complementary outputs outside reset
   p_inverse_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (drive_n == !conduct));

   if (REG_OUT) begin : g_reg_chk
      // R9: one-cycle latency
      p_latency_r9: assert property (@(posedge clk) disable iff (rst)
         !rst |=> (conduct == $past(cond_raw)));
      // R9: synchronous clear
      p_clear_r9: assert property (@(posedge clk)
         rst |=> (!conduct && !drive_n));
   end else begin : g_comb_chk
      p_follow_r9: assert property (@(posedge clk) disable iff (rst)
         conduct == cond_raw);
   end

endmodule

bind bridge_switch_net bsn_checker #(
   .N_SW    (N_SW),
   .REG_OUT (REG_OUT)
) u_bsn_checker (
   .clk       (clk),
   .rst       (rst),
   .sw_ctrl   (sw_ctrl),
   .stk_short (stk_short),
   .stk_open  (stk_open),
   .cond_raw  (cond_raw),
   .conduct   (conduct),
   .drive_n   (drive_n)
);

// File: tb/bridge_switch_net_bench.sv
`timescale 1ns/1ps
module bridge_switch_net_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] sw_ctrl = '0;
   logic [4:0] stk_short = '0;
   logic [4:0] stk_open = '0;
   logic       conduct;
   logic       drive_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   bridge_switch_net u_bridge_switch_net (
      .clk       (clk),
      .rst       (rst),
      .sw_ctrl   (sw_ctrl),
      .stk_short (stk_short),
      .stk_open  (stk_open),
      .conduct   (conduct),
      .drive_n   (drive_n)
   );

   // Behavioural reference: resolve each element, then test the four paths
   function automatic logic ref_conduct(input logic [4:0] c, input logic [4:0] s,
                                        input logic [4:0] o);
      logic [4:0] e;
      for (int i = 0; i < 5; i++) begin
         if (o[i])      e[i] = 1'b0;
         else if (s[i]) e[i] = 1'b1;
         else           e[i] = c[i];
      end
      return (e[0] & e[3]) | (e[1] & e[4]) | (e[0] & e[2] & e[4]) | (e[1] & e[2] & e[3]);
   endfunction

   task automatic check(input string tag, input logic act_c, input logic act_d,
                        input logic exp_c, input logic exp_d);
      n_checks++;
      if (act_c !== exp_c || act_d !== exp_d) begin
         n_fail++;
         $display("FAIL %s: conduct/drive_n = %b/%b, expected %b/%b",
                  tag, act_c, act_d, exp_c, exp_d);
      end
   endtask

   task automatic apply(input string tag, input logic [4:0] c, input logic [4:0] s,
                        input logic [4:0] o);
      logic exp;
      @(negedge clk);
      sw_ctrl = c; stk_short = s; stk_open = o;
      exp = ref_conduct(c, s, o);
      @(posedge clk);
      #1;
      check(tag, conduct, drive_n, exp, ~exp);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check("R9 reset state", conduct, drive_n, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b0;

      // R7 / R1 / R2: healthy sweep
      for (int c = 0; c < 32; c++) apply("R7 R1 R2 fault-free", 5'(c), '0, '0);

      // R8: both crossing paths
      apply("R8 cross e0-e2-e4", 5'b10101, '0, '0);
      apply("R8 cross e1-e2-e3", 5'b01110, '0, '0);
      apply("R8 bridge open blocks cross", 5'b10101, '0, 5'b00100);

      // R3 / R4 / R5: single-element faults across all controls
      for (int i = 0; i < 5; i++) begin
         for (int c = 0; c < 32; c++) begin
            apply("R3 stuck-short", 5'(c), 5'(1 << i), '0);
            apply("R4 stuck-open", 5'(c), '0, 5'(1 << i));
            apply("R5 short+open on one element", 5'(c), 5'(1 << i), 5'(1 << i));
         end
      end

      // R6: random multiple faults
      for (int k = 0; k < 400; k++)
         apply("R6 multiple faults", 5'($urandom), 5'($urandom), 5'($urandom));

      // R9: latency - output holds the old value until the next edge
      apply("R9 setup conducting", 5'b01001, '0, '0);
      @(negedge clk);
      sw_ctrl = 5'b00000;
      #1;
      check("R9 latency hold", conduct, drive_n, 1'b1, 1'b0);
      @(posedge clk);
      #1;
      check("R9 latency update", conduct, drive_n, 1'b0, 1'b1);

      // R9: reset raised while conducting clears both outputs
      apply("R9 pre-reset", 5'b11111, '0, '0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R9 reset mid-run", conduct, drive_n, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      apply("R9 after reset", 5'b11111, '0, '0);

      done = 1'b1;
      finish_run();
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung, expected done");
         finish_run();
      end
   end

endmodule